// File: doc/BRIEF.md
# Programmable Serial Pattern Matcher

The block receives a serial bit stream, one bit per cycle in which the valid strobe is high. It keeps the most recent received bits in a sliding window and compares that window against a pattern register that can be rewritten while the block runs. When the window equals the pattern, the block raises a single-cycle match pulse. Every alignment is tested, so occurrences that overlap are all reported.

The equality check runs in two registered stages so that the logic between flops stays shallow. First the per-bit equalities are ANDed in small groups. Then the group results are ANDed. The pulse therefore comes out a fixed two edges after the edge that shifts in the final bit. A small controller gates the pipeline with three named states. FILL waits until the window holds a full width of bits received since reset. ARMED lets results through. BLANK holds for the pipeline depth after a pattern write. The transitions are: FILL to ARMED when the window becomes full; any state to BLANK on a pattern write; and BLANK to ARMED (or back to FILL if the window is still not full) after two cycles. Results computed across a pattern change are dropped.

Top module: `psm_matcher`

## Requirements
- R1: A bit sampled with `in_valid` high enters the window at the least significant end. The window's top bit holds the oldest of the last `WIN_W` (default 24) bits, and `pat_data` uses the same ordering: its bit 0 is compared with the newest bit.
- R2: If the bit shifted in at clock edge k makes the window equal the pattern, `match` is high for exactly the cycle that follows edge k+2, unless R6, R7 or R8 suppress it.
- R3: Overlapping occurrences are each reported. A stream of ones against an all-ones pattern pulses once for every valid bit from the 24th onward.
- R4: A write with `pat_we` high loads `pat_data` into the pattern register at that clock edge, and later bits are compared with the new value.
- R5: Synchronous active-high `rst` clears the window, the pipeline and `match`, and sets the pattern to all zeros. After reset, 24 zero bits with no write give a match.
- R6: No match comes from a bit that is earlier than the 24th valid bit received since reset.
- R7: A cycle with `in_valid` low leaves the window unchanged and adds no pulse of its own. `in_bit` is ignored in that cycle, and pulses already in the pipeline still emerge.
- R8: After a pattern write at edge w, bits shifted in at edges w-2 through w+1 produce no pulse, so `match` stays low for the four cycles after w.
- R9: With `WIN_W` = 8 and pattern 8'hAB, the block fires exactly when the last eight bits, oldest first, are 1,0,1,0,1,0,1,1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_bit` carries a stream bit |
| in_bit | input | 1 | Serial data bit |
| pat_we | input | 1 | Pattern write strobe |
| pat_data | input | WIN_W | New pattern value, bit 0 compared with the newest bit |
| match | output | 1 | One-cycle pulse, two edges after the completing bit |

## Verification
The assertions assume that `pat_we` and `in_valid` are never unknown after reset. They also assume that reset is held for at least one edge before the stream starts, so that looking three or four cycles back after reset only sees cleared pipeline state. The bench drives both strobes from known values on every cycle. It asserts reset before each table entry and before each directed case. It keeps its writes away from stream starts except in the blanking case, where the overlap with a write is exactly what is being tested.

// File: rtl/psm_pkg.sv
package psm_pkg;
    // Registered stages between the window and the match flop.
    localparam int PSM_PIPE_DEPTH = 2;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BLANK = 2'd2
    } psm_state_e;
endpackage

// File: rtl/psm_window.sv
module psm_window #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_bit,
    output logic [W-1:0] win,
    output logic         shifted,
    output logic         full_next
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  win_q;
    logic [CW-1:0] cnt_q;

    // Newest bit at bit 0, oldest at the top.
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q   <= '0;
            cnt_q   <= '0;
            shifted <= 1'b0;
        end else begin
            shifted <= in_valid;
            if (in_valid) begin
                win_q <= {win_q[W-2:0], in_bit};
                if (cnt_q != CW'(W)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // The window is full after this edge.
    assign full_next = (cnt_q == CW'(W)) || ((cnt_q == CW'(W - 1)) && in_valid);
    assign win       = win_q;
endmodule

// File: rtl/psm_cmp_pipe.sv
module psm_cmp_pipe #(
    parameter int W = 24,
    parameter int G = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] win,
    input  logic [W-1:0] pattern,
    input  logic         tok_in,
    input  logic         gate,
    output logic         match
);
    localparam int NGRP = (W + G - 1) / G;
    localparam int PW   = NGRP * G;

    logic [W-1:0]    eqv;
    logic [PW-1:0]   eq_pad;
    logic [NGRP-1:0] grp_q;
    logic            tok_q;
    logic            match_q;

    assign eqv = ~(win ^ pattern);

    // Pad the top group with ones when W is not a multiple of G.
    for (genvar i = 0; i < PW; i++) begin : g_pad
        if (i < W) begin : g_bit
            assign eq_pad[i] = eqv[i];
        end else begin : g_one
            assign eq_pad[i] = 1'b1;
        end
    end

    // Stage 1: per-group AND.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst) begin
                grp_q[g] <= 1'b0;
            end else begin
                grp_q[g] <= &eq_pad[g*G +: G];
            end
        end
    end

    // Token travels with the group results; stage 2 reduces the groups.
    always_ff @(posedge clk) begin
        if (rst) begin
            tok_q   <= 1'b0;
            match_q <= 1'b0;
        end else begin
            tok_q   <= tok_in && gate;
            match_q <= tok_q && gate && (&grp_q);
        end
    end

    assign match = match_q;
endmodule

// File: rtl/psm_ctrl.sv
module psm_ctrl
    import psm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pat_we,
    input  logic full_next,
    output logic gate
);
    localparam int BCW = (PSM_PIPE_DEPTH > 1) ? $clog2(PSM_PIPE_DEPTH) : 1;

    psm_state_e     state_q, state_d;
    logic [BCW-1:0] bcnt_q, bcnt_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            bcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            bcnt_q  <= bcnt_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        bcnt_d  = bcnt_q;
        if (pat_we) begin
            state_d = ST_BLANK;
            bcnt_d  = '0;
        end else begin
            unique case (state_q)
                ST_FILL: begin
                    if (full_next) begin
                        state_d = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    state_d = ST_ARMED;
                end
                ST_BLANK: begin
                    if (bcnt_q == BCW'(PSM_PIPE_DEPTH - 1)) begin
                        state_d = full_next ? ST_ARMED : ST_FILL;
                        bcnt_d  = '0;
                    end else begin
                        bcnt_d  = bcnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_FILL;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            ST_ARMED: gate = !pat_we;
            ST_FILL:  gate = 1'b0;
            ST_BLANK: gate = 1'b0;
            default:  gate = 1'b0;
        endcase
    end
endmodule

// File: rtl/psm_matcher.sv
module psm_matcher #(
    parameter int WIN_W = 24,
    parameter int GRP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic             pat_we,
    input  logic [WIN_W-1:0] pat_data,
    output logic             match
);
    logic [WIN_W-1:0] win;
    logic [WIN_W-1:0] pat_q;
    logic             shifted;
    logic             full_next;
    logic             gate;

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '0;
        end else if (pat_we) begin
            pat_q <= pat_data;
        end
    end

    psm_window #(.W(WIN_W)) u_win (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .win       (win),
        .shifted   (shifted),
        .full_next (full_next)
    );

    psm_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pat_we    (pat_we),
        .full_next (full_next),
        .gate      (gate)
    );

    psm_cmp_pipe #(.W(WIN_W), .G(GRP_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .win     (win),
        .pattern (pat_q),
        .tok_in  (shifted),
        .gate    (gate),
        .match   (match)
    );
endmodule

// File: rtl/psm_matcher_chk.sv
module psm_matcher_chk #(
    parameter int W = 24
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic pat_we,
    input logic match
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] vcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt <= '0;
        end else if (in_valid && vcnt != CW'(W)) begin
            vcnt <= vcnt + 1'b1;
        end
    end

    // R5: reset clears the output.
    p_reset_clears_r5: assert property (@(posedge clk) rst |=> !match);

    // R7: a pulse needs a valid bit three edges earlier.
    p_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
        match |-> $past(in_valid, 3));

    // R6: no pulse before a full window of valid bits.
    p_fill_first_r6: assert property (@(posedge clk) disable iff (rst)
        match |-> (vcnt == CW'(W)));

    // R8: quiet for four cycles after a pattern write.
    p_blank_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(pat_we, 1) || $past(pat_we, 2) || $past(pat_we, 3) || $past(pat_we, 4))
        |-> !match);

    // R2: back-to-back pulses need back-to-back valid bits.
    p_pulse_pair_r2: assert property (@(posedge clk) disable iff (rst)
        (match && $past(match)) |-> ($past(in_valid, 3) && $past(in_valid, 4)));
endmodule

bind psm_matcher psm_matcher_chk #(.W(WIN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .pat_we   (pat_we),
    .match    (match)
);

// File: tb/tb_psm_matcher.sv
module tb_psm_matcher;
    localparam int NTAB = 6;
    localparam int AMAX = 8192;

    // {pattern[23:0], stream[47:0] msb first, expected pulses[7:0]}
    localparam logic [79:0] TAB [NTAB] = '{
        {24'hABCDEF, 48'hABCDEF_ABCDEF, 8'd2},
        {24'hFFFFFF, 48'hFFFFFF_FFFFFF, 8'd25},
        {24'h000000, 48'h000000_000000, 8'd25},
        {24'hAAAAAA, 48'hAAAAAA_AAAAAA, 8'd13},
        {24'h123456, 48'h000000_FFFFFF, 8'd0},
        {24'h800001, 48'h800001_800001, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_bit = 1'b0;
    logic        pat_we = 1'b0;
    logic [23:0] pat_data = '0;
    logic        match;
    logic        match8;

    int n_chk = 0;
    int n_fail = 0;
    int n = 0;
    int pulses = 0;
    int pulses8 = 0;

    logic [63:0] hist = '0;
    int          cnt = 0;
    logic [23:0] patm = '0;
    logic [7:0]  pat8 = '0;
    bit vld_a [AMAX];
    bit we_a  [AMAX];
    bit ok24_a[AMAX];
    bit ok8_a [AMAX];

    always #5 clk = ~clk;

    psm_matcher dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
        .pat_we(pat_we), .pat_data(pat_data), .match(match)
    );

    psm_matcher #(.WIN_W(8), .GRP_W(4)) dut8 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
        .pat_we(pat_we), .pat_data(8'hAB), .match(match8)
    );

    task automatic chk(input bit cond, input string tag, input logic act, input logic exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: match got %0b expected %0b (edge %0d)", tag, act, exp, n);
        end
    endtask

    function automatic logic expect_at(input int nn, input bit is8);
        int k = nn - 2;
        if (k < 1) return 1'b0;
        if (!vld_a[k]) return 1'b0;
        for (int j = k - 1; j <= k + 2; j++) begin
            if (j >= 1 && we_a[j]) return 1'b0;
        end
        return is8 ? ok8_a[k] : ok24_a[k];
    endfunction

    // One cycle: drive at the falling edge, model at the rising edge, check at the next falling edge.
    task automatic step(input logic r, input logic v, input logic b,
                        input logic we, input logic [23:0] pd);
        rst = r; in_valid = v; in_bit = b; pat_we = we; pat_data = pd;
        @(posedge clk);
        n++;
        if (r) begin
            hist = '0; cnt = 0; patm = '0; pat8 = '0;
            vld_a[n] = 0; we_a[n] = 0;
            if (n >= 1) vld_a[n-1] = 0;
            if (n >= 2) vld_a[n-2] = 0;
        end else begin
            if (v) begin
                hist = {hist[62:0], b};
                if (cnt < 64) cnt++;
            end
            if (we) begin
                patm = pd;
                pat8 = 8'hAB;
            end
            vld_a[n] = v;
            we_a[n]  = we;
        end
        ok24_a[n] = (cnt >= 24) && (hist[23:0] == patm);
        ok8_a[n]  = (cnt >= 8) && (hist[7:0] == pat8);
        @(negedge clk);
        chk(match === expect_at(n, 1'b0), "R2 R1 R4 R6 R7 model, 24-bit", match, expect_at(n, 1'b0));
        chk(match8 === expect_at(n, 1'b1), "R9 model, 8-bit", match8, expect_at(n, 1'b1));
        if (match === 1'b1) pulses++;
        if (match8 === 1'b1) pulses8++;
    endtask

    task automatic do_reset();
        step(1'b1, 1'b0, 1'b0, 1'b0, 24'h0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 24'h0);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 24'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R5: output low in reset.
        chk(match === 1'b0, "R5 reset state", match, 1'b0);

        // Table: each entry twice, dense then with an idle cycle per bit (R7).
        for (int e = 0; e < NTAB; e++) begin
            for (int mode = 0; mode < 2; mode++) begin
                logic [23:0] tp = TAB[e][79:56];
                logic [47:0] ts = TAB[e][55:8];
                int          th = int'(TAB[e][7:0]);
                do_reset();
                step(1'b0, 1'b0, 1'b0, 1'b1, tp);
                pulses = 0;
                for (int j = 47; j >= 0; j--) begin
                    step(1'b0, 1'b1, ts[j], 1'b0, 24'h0);
                    if (mode == 1) step(1'b0, 1'b0, ~ts[j], 1'b0, 24'h0);
                end
                idle(4);
                chk(pulses == th, mode == 0 ? "R3 R4 table dense" : "R7 table with gaps",
                    logic'(pulses == th), 1'b1);
                if (pulses != th) $display("FAIL R3: pulses %0d expected %0d entry %0d", pulses, th, e);
            end
        end

        // R5 and R6: zero pattern after reset, zeros stream; the 24th bit is the first to fire.
        do_reset();
        pulses = 0;
        for (int j = 0; j < 23; j++) step(1'b0, 1'b1, 1'b0, 1'b0, 24'h0);
        idle(3);
        chk(pulses == 0, "R6 no pulse before 24 bits", logic'(pulses != 0), 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0, 24'h0);
        idle(1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 24'h0);
        chk(match === 1'b1, "R5 R2 zero pattern fires two edges later", match, 1'b1);

        // R1: ordering, oldest bit 1 at the top, newest 0.
        do_reset();
        step(1'b0, 1'b0, 1'b0, 1'b1, 24'h800000);
        step(1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
        for (int j = 0; j < 23; j++) step(1'b0, 1'b1, 1'b0, 1'b0, 24'h0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 24'h0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 24'h0);
        chk(match === 1'b1, "R1 oldest bit at top", match, 1'b1);

        // R7: idle cycles with toggling data keep the window of ones.
        do_reset();
        step(1'b0, 1'b0, 1'b0, 1'b1, 24'hFFFFFF);
        for (int j = 0; j < 26; j++) step(1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
        for (int j = 0; j < 5; j++) step(1'b0, 1'b0, j[0], 1'b0, 24'h0);
        chk(match === 1'b0, "R7 no pulse from idle cycles", match, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 24'h0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 24'h0);
        chk(match === 1'b1, "R7 window unchanged across idle", match, 1'b1);

        // R8: rewrite during a stream of ones.
        for (int j = 0; j < 6; j++) step(1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
        step(1'b0, 1'b1, 1'b1, 1'b1, 24'hFFFFFF);
        chk(match === 1'b0, "R8 blank cycle 1", match, 1'b0);
        for (int j = 2; j <= 4; j++) begin
            step(1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
            chk(match === 1'b0, "R8 blank cycles 2..4", match, 1'b0);
        end
        step(1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
        chk(match === 1'b1, "R8 pulses resume", match, 1'b1);

        // R4: a new pattern stops the old one from matching.
        step(1'b0, 1'b0, 1'b0, 1'b1, 24'h00000F);
        for (int j = 0; j < 8; j++) step(1'b0, 1'b1, 1'b1, 1'b0, 24'h0);
        chk(match === 1'b0, "R4 old pattern no longer matches", match, 1'b0);

        // R9: 8-bit instance, stream 0xABAB.
        do_reset();
        step(1'b0, 1'b0, 1'b0, 1'b1, 24'h0);
        pulses8 = 0;
        for (int j = 15; j >= 0; j--) step(1'b0, 1'b1, (16'hABAB >> j) & 1'b1, 1'b0, 24'h0);
        idle(4);
        chk(pulses8 == 2, "R9 8-bit reference pattern count", logic'(pulses8 == 2), 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule